// File: doc/BRIEF.md
# Multichannel PWM Timer with IR Carrier Gating

This block is a 16-bit up-counter with five channels. Each channel either drives a pulse-width output that is derived from its own compare value, or timestamps edges on an input pin by latching the counter. The counter is advanced by a prescaler that divides the clock by 1, 8, 32 or 128. It runs from zero up to a programmable period and then returns to zero. Period and compare values are written to shadow registers. These copy into the active registers only when the counter wraps, or at once while the timer is stopped, so a running waveform never shows a half-updated cycle.

A small 8-bit carrier timer sits beside the main counter. It has its own prescaler, period and compare value, and it produces a square-wave carrier. In IR mode the main counter advances once per completed carrier period instead of once per prescaler tick. One selected channel output is then ANDed with the carrier, so a modulated burst with an exact number of carrier pulses comes out with no software involvement. Software configures the block through a write-enable/address/data port and reads registers back combinationally on the same address. Capture events and counter wraps raise sticky flags that can drive an interrupt.

Top module: `pwm_ir_timer`

## Requirements
- R1: Register map by `addr`. 0 is control: [0] run, [2:1] main prescale select, [4:3] carrier prescale select, [5] IR mode, [8:6] IR channel. 1 is the main period. 2+i is the compare value of channel i; in capture mode a read returns the captured value. 7 is the channel mode: bits [3i] capture enable and [3i+2:3i+1] edge select for channel i. 8 holds the flags: [4:0] capture, [5] wrap. 9 is the interrupt enable [5:0]. 10 is the carrier: [7:0] period, [15:8] compare. 11 reads the counter. A written control or period value reads back unchanged.
- R2: After reset the counter reads 0, and all channel outputs, `carrier_out` and `irq` are low.
- R3: A prescale select of 0, 1, 2 or 3 advances the counter once every 1, 8, 32 or 128 clocks. After the counter reaches the period it returns to 0, and it never reads above the period once running.
- R4: A compare-mode channel is high while the counter is below its compare value and low otherwise. A compare value of 0 keeps it low, and a compare value above the period keeps it high.
- R5: Period and compare writes made while running take effect only after the next wrap. While the timer is stopped they take effect at once.
- R6: A capture channel latches the counter value two clocks after its pin changes, on the selected edge. Edge select 01 is rising, 10 is falling and 11 is both. The capture also sets that channel's flag.
- R7: Edge select 00, or an edge of the unselected polarity, changes neither the captured value nor the flag.
- R8: Writing 1 to a flag bit clears it, while a 0 leaves the bit alone. The wrap flag sets on every counter wrap.
- R9: `irq` is high exactly when some set flag has its enable bit set.
- R10: The carrier output is high while the carrier count is below the carrier compare value. The carrier period is the period value + 1 ticks of its own prescaler, whose select encoding matches R3.
- R11: In IR mode the main counter advances once per carrier period.
- R12: In IR mode only the selected channel is ANDed with the carrier; the other channels are unchanged.
- R13: A channel in capture mode drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data at `addr` |
| cap_in | input | 5 | Capture input pins, one per channel |
| ch_out | output | 5 | Channel outputs |
| carrier_out | output | 1 | Carrier timer PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures duty cycles by counting high clocks over a whole period. A comparator that is off by one, or a compare of 0 or above the period handled wrongly, therefore shows up as a wrong count. It rewrites a compare value mid-period and watches the next clock. A design without shadowing would turn the output high early. Captures are checked against the counter value read when the pin changes plus the two-clock synchronizer delay, so a missing or extra flop gives a wrong value. The unselected polarity and the none setting must leave both flag and value untouched. In IR mode the bench checks that the counter rate follows the carrier period. It also checks that only the selected channel loses half its high time, which catches gating applied to the wrong channel or to every channel.

// File: rtl/pwm_ir_timer.sv
module pwm_ir_timer #(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int KW  = 8,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] ch_out,
  output logic          carrier_out,
  output logic          irq
);
  localparam int FW = NCH + 1;
  localparam int MW = 3 * NCH;
  localparam int SW = $clog2(NCH);
  localparam int PW = 7;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PER  = AW'(1);
  localparam logic [AW-1:0] A_CMP0 = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(2 + NCH);
  localparam logic [AW-1:0] A_FLG  = AW'(3 + NCH);
  localparam logic [AW-1:0] A_IEN  = AW'(4 + NCH);
  localparam logic [AW-1:0] A_KAR  = AW'(5 + NCH);
  localparam logic [AW-1:0] A_CNT  = AW'(6 + NCH);

  function automatic logic [PW-1:0] div_lim(input logic [1:0] s);
    case (s)
      2'd0:    return PW'(0);
      2'd1:    return PW'(7);
      2'd2:    return PW'(31);
      default: return PW'(127);
    endcase
  endfunction

  logic run, ir;
  logic [1:0] mps, cps;
  logic [SW-1:0] irs;
  logic [CW-1:0] per_sh, per_act, cnt;
  logic [CW-1:0] cmp_sh [NCH];
  logic [CW-1:0] cmp_act[NCH];
  logic [CW-1:0] cap_q  [NCH];
  logic [MW-1:0] mode;
  logic [FW-1:0] flg, ien;
  logic [KW-1:0] kper_sh, kcmp_sh, kper_act, kcmp_act, kcnt;
  logic [PW-1:0] mpre, kpre;
  logic [NCH-1:0] s1, s2, s3, cap_evt, capm;

  wire ktick = run & (kpre >= div_lim(cps));
  wire kwrap = ktick & (kcnt >= kper_act);
  wire mtick = run & (ir ? kwrap : (mpre >= div_lim(mps)));
  wire mwrap = mtick & (cnt >= per_act);
  wire wr_flg = wr_en && addr == A_FLG;

  assign carrier_out = kcnt < kcmp_act;
  assign irq = |(flg & ien);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; ir <= 1'b0; mps <= '0; cps <= '0; irs <= '0;
      per_sh <= '0; mode <= '0; ien <= '0; kper_sh <= '0; kcmp_sh <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run <= wdata[0]; mps <= wdata[2:1]; cps <= wdata[4:3];
          ir <= wdata[5]; irs <= wdata[6 +: SW];
        end
        A_PER:  per_sh <= wdata;
        A_MODE: mode <= wdata[MW-1:0];
        A_IEN:  ien <= wdata[FW-1:0];
        A_KAR:  begin kper_sh <= wdata[KW-1:0]; kcmp_sh <= wdata[KW +: KW]; end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mpre <= '0; kpre <= '0; cnt <= '0; kcnt <= '0;
      per_act <= '0; kper_act <= '0; kcmp_act <= '0;
    end else begin
      mpre <= (!run || mpre >= div_lim(mps)) ? '0 : mpre + 1'b1;
      kpre <= (!run || ktick) ? '0 : kpre + 1'b1;
      if (ktick) kcnt <= kwrap ? '0 : kcnt + 1'b1;
      if (mtick) cnt <= mwrap ? '0 : cnt + 1'b1;
      if (!run || mwrap) per_act <= per_sh;
      if (!run || kwrap) begin
        kper_act <= kper_sh;
        kcmp_act <= kcmp_sh;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      flg <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      flg <= (flg & ~(wr_flg ? wdata[FW-1:0] : '0)) | {mwrap, cap_evt};
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = CW'({irs, ir, cps, mps, run});
      A_PER:  rdata = per_sh;
      A_MODE: rdata = CW'(mode);
      A_FLG:  rdata = CW'(flg);
      A_IEN:  rdata = CW'(ien);
      A_KAR:  rdata = CW'({kcmp_sh, kper_sh});
      A_CNT:  rdata = cnt;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (addr == A_CMP0 + AW'(i)) rdata = capm[i] ? cap_q[i] : cmp_sh[i];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire [1:0] edg = mode[3*i+1 +: 2];
    wire rise = s2[i] & ~s3[i];
    wire fall = ~s2[i] & s3[i];
    assign capm[i] = mode[3*i];
    assign cap_evt[i] = capm[i] & ((edg[0] & rise) | (edg[1] & fall));
    wire pwm  = !capm[i] && (cnt < cmp_act[i]);
    wire pass = !ir || (irs != SW'(i)) || carrier_out;
    assign ch_out[i] = pwm & pass;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmp_sh[i] <= '0; cmp_act[i] <= '0; cap_q[i] <= '0;
      end else begin
        if (wr_en && addr == A_CMP0 + AW'(i)) cmp_sh[i] <= wdata;
        if (!run || mwrap) cmp_act[i] <= cmp_sh[i];
        if (cap_evt[i]) cap_q[i] <= cnt;
      end

    // R4
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!capm[i] && cmp_act[i] == '0) |-> !ch_out[i]);
    // R6
    cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> flg[i]);
    // R12
    ir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ir && irs == SW'(i) && !carrier_out) |-> !ch_out[i]);
    // R13
    cap_mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capm[i] |-> !ch_out[i]);
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mtick |=> $stable(cnt));
  // R11
  ir_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir && !kwrap) |=> $stable(cnt));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/sim_pwm_ir_timer.sv
module sim_pwm_ir_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [4:0] cap_in = '0;
  logic [15:0] rdata;
  logic [4:0] ch_out;
  logic carrier_out, irq;
  int n_chk = 0, n_fail = 0;

  pwm_ir_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .ch_out(ch_out), .carrier_out(carrier_out), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); addr = a; #1 d = int'(rdata);
  endtask

  task automatic high_cnt(input int which, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (which == 5 ? carrier_out : ch_out[which]) h++;
    end
  endtask

  task automatic rate(input int n, input int modulus, output int d);
    int c0, c1;
    @(negedge clk); addr = 4'd11; #1 c0 = int'(rdata);
    repeat (n) @(negedge clk);
    #1 c1 = int'(rdata);
    d = (c1 + modulus - c0) % modulus;
  endtask

  task automatic t_reset;
    int v;
    rd(4'd11, v); chk("R2 counter", v, 0);
    chk("R2 ch_out", int'(ch_out), 0);
    chk("R2 carrier", int'(carrier_out), 0);
    chk("R2 irq", int'(irq), 0);
    wr(4'd1, 16'd1234); rd(4'd1, v); chk("R1 period readback", v, 1234);
    wr(4'd0, 16'h01a4); rd(4'd0, v); chk("R1 ctrl readback", v, 'h1a4);
    wr(4'd0, 16'h0);
  endtask

  task automatic t_prescale;
    int d, mx, v;
    wr(4'd1, 16'd1000);
    for (int s = 0; s < 4; s++) begin
      int div;
      div = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 128;
      wr(4'd0, 16'(1 | (s << 1)));
      repeat (5) @(negedge clk);
      rate(10 * div, 1001, d);
      chk($sformatf("R3 ticks div %0d", div), d, 10);
      wr(4'd0, 16'h0);
    end
    wr(4'd1, 16'd9); wr(4'd0, 16'h1);
    repeat (5) @(negedge clk);
    mx = 0;
    for (int k = 0; k < 30; k++) begin
      rd(4'd11, v);
      if (v > mx) mx = v;
    end
    chk("R3 wraps at period", mx, 9);
  endtask

  task automatic t_pwm;
    int h;
    wr(4'd0, 16'h0); wr(4'd1, 16'd9);
    wr(4'd2, 16'd3); wr(4'd3, 16'd0); wr(4'd4, 16'd12);
    wr(4'd0, 16'h1);
    repeat (25) @(negedge clk);
    high_cnt(0, 10, h); chk("R4 duty 3/10", h, 3);
    high_cnt(1, 10, h); chk("R4 compare 0 low", h, 0);
    high_cnt(2, 10, h); chk("R4 compare above period high", h, 10);
  endtask

  task automatic t_shadow;
    int h, guard;
    guard = 0;
    addr = 4'd11;
    do begin
      @(negedge clk); #1; guard++;
    end while (rdata != 16'd4 && guard < 100);
    wr_en = 1'b1; addr = 4'd2; wdata = 16'd8;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R5 no mid-period update", int'(ch_out[0]), 0);
    repeat (25) @(negedge clk);
    high_cnt(0, 10, h); chk("R5 new compare after wrap", h, 8);
  endtask

  task automatic t_capture;
    int c0, v, old;
    wr(4'd0, 16'h0); wr(4'd1, 16'd1000);
    wr(4'd7, 16'((3 << 9) | (3 << 12)));
    wr(4'd8, 16'h3f); wr(4'd0, 16'h1);
    repeat (5) @(negedge clk);
    @(negedge clk); addr = 4'd11; #1 c0 = int'(rdata); cap_in[3] = 1'b1; cap_in[4] = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'd5, v); chk("R6 rising capture ch3", v, (c0 + 2) % 1001);
    rd(4'd6, v); chk("R6 rising capture ch4", v, (c0 + 2) % 1001);
    rd(4'd8, v); chk("R6 flags set", v & 'h18, 'h18);
    old = (c0 + 2) % 1001;
    wr(4'd8, 16'h18);
    @(negedge clk); cap_in[3] = 1'b0; cap_in[4] = 1'b0;
    repeat (6) @(negedge clk);
    rd(4'd8, v); chk("R7 falling ignored flag", v & 'h18, 0);
    rd(4'd5, v); chk("R7 falling ignored value", v, old);
    wr(4'd7, 16'(7 << 9));
    @(negedge clk); cap_in[3] = 1'b1;
    repeat (6) @(negedge clk);
    wr(4'd8, 16'h3f);
    @(negedge clk); addr = 4'd11; #1 c0 = int'(rdata); cap_in[3] = 1'b0;
    repeat (6) @(negedge clk);
    rd(4'd5, v); chk("R6 both-edge falling capture", v, (c0 + 2) % 1001);
    old = v;
    wr(4'd7, 16'(1 << 9)); wr(4'd8, 16'h3f);
    @(negedge clk); cap_in[3] = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'd8, v); chk("R7 edge none flag", v & 'h8, 0);
    rd(4'd5, v); chk("R7 edge none value", v, old);
    @(negedge clk); cap_in[3] = 1'b0;
    repeat (6) @(negedge clk);
    wr(4'd0, 16'h0); wr(4'd1, 16'd9); wr(4'd5, 16'd8); wr(4'd0, 16'h1);
    high_cnt(3, 20, v); chk("R13 capture channel low", v, 0);
  endtask

  task automatic t_flags;
    int v;
    wr(4'd7, 16'((3 << 9) | (3 << 12)));
    wr(4'd8, 16'h3f); wr(4'd9, 16'h10);
    @(negedge clk); #1; chk("R9 irq idle", int'(irq), 0);
    @(negedge clk); cap_in[3] = 1'b1; cap_in[4] = 1'b1;
    repeat (6) @(negedge clk); #1;
    chk("R9 irq on enabled flag", int'(irq), 1);
    wr(4'd8, 16'h08);
    rd(4'd8, v);
    chk("R8 cleared bit", v & 'h08, 0);
    chk("R8 other bit kept", v & 'h10, 'h10);
    chk("R8 wrap flag", v & 'h20, 'h20);
    wr(4'd8, 16'h10);
    @(negedge clk); #1; chk("R9 irq after clear", int'(irq), 0);
    @(negedge clk); cap_in = '0;
    repeat (6) @(negedge clk);
    wr(4'd7, 16'h0); wr(4'd9, 16'h0);
  endtask

  task automatic t_carrier;
    int h;
    wr(4'd0, 16'h0); wr(4'd10, 16'((2 << 8) | 3)); wr(4'd0, 16'h1);
    repeat (10) @(negedge clk);
    high_cnt(5, 40, h); chk("R10 carrier div1", h, 20);
    wr(4'd0, 16'h0); wr(4'd0, 16'(1 | (1 << 3)));
    repeat (40) @(negedge clk);
    high_cnt(5, 64, h); chk("R10 carrier div8", h, 32);
  endtask

  task automatic t_ir;
    int d, h;
    wr(4'd0, 16'h0); wr(4'd1, 16'd1000); wr(4'd10, 16'((2 << 8) | 3));
    wr(4'd0, 16'(1 | (1 << 5)));
    repeat (10) @(negedge clk);
    rate(40, 1001, d); chk("R11 counts carrier periods", d, 10);
    wr(4'd0, 16'h0); wr(4'd1, 16'd4); wr(4'd2, 16'd2); wr(4'd3, 16'd2);
    wr(4'd0, 16'(1 | (1 << 5)));
    repeat (30) @(negedge clk);
    high_cnt(0, 20, h); chk("R12 selected channel gated", h, 4);
    high_cnt(1, 20, h); chk("R12 other channel ungated", h, 8);
    wr(4'd0, 16'(1 | (1 << 5) | (1 << 6)));
    repeat (20) @(negedge clk);
    high_cnt(0, 20, h); chk("R12 deselected channel ungated", h, 8);
    high_cnt(1, 20, h); chk("R12 newly selected gated", h, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_pwm;
    t_shadow;
    t_capture;
    t_flags;
    t_carrier;
    t_ir;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule